// File: doc/BRIEF.md
# SPI Transfer Sequencer

This block walks a byte-wide SPI shift engine through a message built from one or more transfers. Each transfer arrives as a descriptor on a valid/ready input. The descriptor carries a byte count, a flag that says whether transmit bytes come from the transmit stream, a flag that says whether received bytes go out on the receive stream, a post-transfer delay in clock ticks, a chip-select change flag and a last-transfer flag. The first descriptor of a message also supplies the device index, the mode bits and the baud setting. These values are held for the whole message and passed unchanged to the engine.

For each byte the sequencer loads the engine with a one-cycle strobe. It then waits for the engine's completion, collision or fault flag. A collision makes it load the same byte again. A fault ends the message with an error. When a transfer's last byte is done, the sequencer counts out the delay, adds the byte count to the message's actual length, and either finishes the message or waits for the next descriptor.

All three streams (descriptor, transmit, receive) follow the same rules. A beat moves on a rising edge where valid and ready are both high. A producer keeps its data stable while valid is high and ready is low. `desc_ready` and `tx_ready` never depend on the matching valid. While the receive stream is held off, the sequencer stalls and loads no further bytes. Engine, chip-select and status pins are plain levels or pulses.

Top module: `spi_seq_top`

## Requirements
- R1: While reset is asserted and after it is released, every `cs_n` bit is high, `msg_status` is 00, `msg_actual` is 0, `desc_ready` is high and `eng_load`, `rx_valid` and `spurious` are low.
- R2: A descriptor accepted while no message is running starts a message. From the next cycle `eng_mode` and `eng_baud` show its mode and baud fields, and the `cs_n` bit numbered by `desc_dev` (bit 0 = device 0) is the only low bit. The device is kept for every transfer of the message.
- R3: Bytes reach the engine in order, one `eng_load` pulse each, with the byte on `eng_wdata`. With `desc_has_tx` = 1 each byte is taken from the transmit stream. With `desc_has_tx` = 0 the byte is 0x00 and `tx_ready` stays low.
- R4: With `desc_store_rx` = 1, each completed byte's `eng_rdata` is offered on `rx_data` with `rx_valid`. It is held stable until `rx_ready`, and no further byte is loaded meanwhile. With `desc_store_rx` = 0, `rx_valid` stays low.
- R5: A completion with `eng_wcol` high reloads the same byte. It does not reduce the remaining count and produces no receive beat.
- R6: `eng_modf` while a byte is in flight releases chip select, sets `msg_status` to 11 and returns to accepting a new message. No further byte of the message is loaded, and `msg_actual` keeps the lengths of transfers already finished.
- R7: After a transfer's final byte completes without a receive beat, the transfer ends exactly delay+1 cycles after the edge that samples that completion. For a last transfer, chip select rises at that point.
- R8: When a transfer that is not last ends, chip select goes high if its change flag is 1 and stays high until the next descriptor is accepted. If the flag is 0, chip select stays low across the boundary.
- R9: `msg_actual` clears to 0 when a message starts, grows by each transfer's length when that transfer ends, and holds its value while the message is done.
- R10: `msg_status` reads 01 from acceptance until the message ends and 10 after a successful end, with all `cs_n` bits high.
- R11: A completion, collision or fault flag that arrives when no byte is in flight pulses `spurious` in the following cycle. It changes no state: no load, no chip-select change, no status or length change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor ready |
| desc_len | input | LEN_W | Transfer byte count |
| desc_has_tx | input | 1 | Transmit bytes come from the stream |
| desc_store_rx | input | 1 | Received bytes go to the stream |
| desc_delay | input | DLY_W | Post-transfer delay in cycles |
| desc_cs_change | input | 1 | Release chip select after this transfer |
| desc_last | input | 1 | Last transfer of the message |
| desc_dev | input | DEV_W | Device index (first descriptor) |
| desc_mode | input | 3 | Engine mode bits (first descriptor) |
| desc_baud | input | 8 | Engine baud setting (first descriptor) |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit byte ready |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Received byte ready |
| rx_data | output | 8 | Received byte |
| eng_mode | output | 3 | Mode bits to engine |
| eng_baud | output | 8 | Baud setting to engine |
| eng_load | output | 1 | One-cycle byte load strobe |
| eng_wdata | output | 8 | Byte to shift out |
| eng_done | input | 1 | Byte complete |
| eng_wcol | input | 1 | Write collision, qualifies eng_done |
| eng_modf | input | 1 | Mode fault |
| eng_rdata | input | 8 | Byte shifted in |
| cs_n | output | NUM_CS | Active-low chip selects |
| msg_status | output | 2 | 00 idle, 01 busy, 10 done ok, 11 done error |
| msg_actual | output | ACT_W | Bytes in finished transfers of the message |
| spurious | output | 1 | Flag seen with no byte in flight |

## Verification
The bench injects a collision on the middle byte of a transfer that also stores received data. A design that advanced the count or stored the collided byte would give the engine one load too few and would put a surplus byte on the receive stream. A fault on the first byte of a second transfer must stop the loads with two bytes still expected and keep the first transfer's length. A design that ignored the fault would drain the expected queue, and one that cleared the length would read 0. Two delay values, including zero, are timed from the completion edge to the chip-select rise, which catches counters that are off by one cycle. Transfer boundaries with the change flag both set and clear are checked by counting chip-select rises, and flags sent while idle or waiting must leave the status, the length and the load count unchanged.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_STORE, ST_WAIT, ST_NEXT
  } seq_state_e;

  typedef enum logic [1:0] {
    MSG_IDLE = 2'b00,
    MSG_BUSY = 2'b01,
    MSG_OK   = 2'b10,
    MSG_ERR  = 2'b11
  } msg_stat_e;
endpackage

// File: rtl/spi_seq_delay.sv
module spi_seq_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             expired
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/spi_seq_csdrv.sv
module spi_seq_csdrv #(
  parameter int NUM_CS = 4,
  parameter int DEV_W  = 2
) (
  input  logic              cs_act,
  input  logic [DEV_W-1:0]  dev,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(cs_act && (dev == DEV_W'(i)));
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DLY_W = 8,
  parameter int DEV_W = 2,
  parameter int ACT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_has_tx,
  input  logic             desc_store_rx,
  input  logic [DLY_W-1:0] desc_delay,
  input  logic             desc_cs_change,
  input  logic             desc_last,
  input  logic [DEV_W-1:0] desc_dev,
  input  logic [2:0]       desc_mode,
  input  logic [7:0]       desc_baud,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic [2:0]       eng_mode,
  output logic [7:0]       eng_baud,
  output logic             eng_load,
  output logic [7:0]       eng_wdata,
  input  logic             eng_done,
  input  logic             eng_wcol,
  input  logic             eng_modf,
  input  logic [7:0]       eng_rdata,
  output logic             dly_load,
  output logic [DLY_W-1:0] dly_val,
  input  logic             dly_expired,
  output logic             cs_act,
  output logic [DEV_W-1:0] cs_dev,
  output logic [1:0]       msg_status,
  output logic [ACT_W-1:0] msg_actual,
  output logic             spurious
);
  seq_state_e       state, state_d;
  logic [LEN_W-1:0] x_len, rem;
  logic [DLY_W-1:0] x_delay;
  logic             x_has_tx, x_store, x_csch, x_last;
  logic [7:0]       byte_q, rx_q, baud_q;
  logic [2:0]       mode_q;
  logic             load_q, cs_q, spur_q;
  logic [DEV_W-1:0] dev_q;
  logic [1:0]       stat_q;
  logic [ACT_W-1:0] act_q;

  logic take, send, resend, fin_byte, abort, to_wait, xfer_end, flag_any;

  assign desc_ready = (state == ST_IDLE) || (state == ST_NEXT);
  assign tx_ready   = (state == ST_LOAD) && x_has_tx;
  assign rx_valid   = (state == ST_STORE);
  assign flag_any   = eng_done || eng_wcol || eng_modf;

  always_comb begin
    state_d  = state;
    take     = 1'b0;
    send     = 1'b0;
    resend   = 1'b0;
    fin_byte = 1'b0;
    abort    = 1'b0;
    to_wait  = 1'b0;
    xfer_end = 1'b0;
    unique case (state)
      ST_IDLE, ST_NEXT: if (desc_valid) begin
        take = 1'b1;
        if (desc_len == '0) begin state_d = ST_WAIT; to_wait = 1'b1; end
        else state_d = ST_LOAD;
      end
      ST_LOAD: if (!x_has_tx || tx_valid) begin
        send    = 1'b1;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (eng_modf) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end else if (eng_done && eng_wcol) begin
          resend = 1'b1;
        end else if (eng_done) begin
          fin_byte = 1'b1;
          if (x_store) state_d = ST_STORE;
          else if (rem == LEN_W'(1)) begin state_d = ST_WAIT; to_wait = 1'b1; end
          else state_d = ST_LOAD;
        end
      end
      ST_STORE: if (rx_ready) begin
        if (rem == '0) begin state_d = ST_WAIT; to_wait = 1'b1; end
        else state_d = ST_LOAD;
      end
      ST_WAIT: if (dly_expired) begin
        xfer_end = 1'b1;
        state_d  = x_last ? ST_IDLE : ST_NEXT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign dly_load = to_wait;
  assign dly_val  = take ? desc_delay : x_delay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      x_len    <= '0;
      rem      <= '0;
      x_delay  <= '0;
      x_has_tx <= 1'b0;
      x_store  <= 1'b0;
      x_csch   <= 1'b0;
      x_last   <= 1'b0;
      byte_q   <= '0;
      rx_q     <= '0;
      mode_q   <= '0;
      baud_q   <= '0;
      load_q   <= 1'b0;
      cs_q     <= 1'b0;
      spur_q   <= 1'b0;
      dev_q    <= '0;
      stat_q   <= MSG_IDLE;
      act_q    <= '0;
    end else begin
      state  <= state_d;
      load_q <= send || resend;
      spur_q <= flag_any && (state != ST_SHIFT);
      if (send) byte_q <= x_has_tx ? tx_data : 8'h00;
      if (take) begin
        x_len    <= desc_len;
        rem      <= desc_len;
        x_delay  <= desc_delay;
        x_has_tx <= desc_has_tx;
        x_store  <= desc_store_rx;
        x_csch   <= desc_cs_change;
        x_last   <= desc_last;
        cs_q     <= 1'b1;
        if (state == ST_IDLE) begin
          mode_q <= desc_mode;
          baud_q <= desc_baud;
          dev_q  <= desc_dev;
          act_q  <= '0;
          stat_q <= MSG_BUSY;
        end
      end
      if (fin_byte) begin
        rem  <= rem - 1'b1;
        rx_q <= eng_rdata;
      end
      if (abort) begin
        cs_q   <= 1'b0;
        stat_q <= MSG_ERR;
      end
      if (xfer_end) begin
        act_q <= act_q + ACT_W'(x_len);
        if (x_last) begin
          cs_q   <= 1'b0;
          stat_q <= MSG_OK;
        end else if (x_csch) begin
          cs_q <= 1'b0;
        end
      end
    end
  end

  assign rx_data    = rx_q;
  assign eng_mode   = mode_q;
  assign eng_baud   = baud_q;
  assign eng_load   = load_q;
  assign eng_wdata  = byte_q;
  assign cs_act     = cs_q;
  assign cs_dev     = dev_q;
  assign msg_status = stat_q;
  assign msg_actual = act_q;
  assign spurious   = spur_q;
endmodule

// File: rtl/spi_seq_top.sv
module spi_seq_top #(
  parameter int LEN_W  = 8,
  parameter int DLY_W  = 8,
  parameter int NUM_CS = 4,
  parameter int ACT_W  = 12,
  localparam int DEV_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_has_tx,
  input  logic              desc_store_rx,
  input  logic [DLY_W-1:0]  desc_delay,
  input  logic              desc_cs_change,
  input  logic              desc_last,
  input  logic [DEV_W-1:0]  desc_dev,
  input  logic [2:0]        desc_mode,
  input  logic [7:0]        desc_baud,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [7:0]        tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [7:0]        rx_data,
  output logic [2:0]        eng_mode,
  output logic [7:0]        eng_baud,
  output logic              eng_load,
  output logic [7:0]        eng_wdata,
  input  logic              eng_done,
  input  logic              eng_wcol,
  input  logic              eng_modf,
  input  logic [7:0]        eng_rdata,
  output logic [NUM_CS-1:0] cs_n,
  output logic [1:0]        msg_status,
  output logic [ACT_W-1:0]  msg_actual,
  output logic              spurious
);
  logic             dly_load, dly_expired, cs_act;
  logic [DLY_W-1:0] dly_val;
  logic [DEV_W-1:0] cs_dev;

  spi_seq_ctrl #(.LEN_W(LEN_W), .DLY_W(DLY_W), .DEV_W(DEV_W), .ACT_W(ACT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_len(desc_len),
    .desc_has_tx(desc_has_tx), .desc_store_rx(desc_store_rx), .desc_delay(desc_delay),
    .desc_cs_change(desc_cs_change), .desc_last(desc_last), .desc_dev(desc_dev),
    .desc_mode(desc_mode), .desc_baud(desc_baud),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_mode(eng_mode), .eng_baud(eng_baud), .eng_load(eng_load), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_wcol(eng_wcol), .eng_modf(eng_modf), .eng_rdata(eng_rdata),
    .dly_load(dly_load), .dly_val(dly_val), .dly_expired(dly_expired),
    .cs_act(cs_act), .cs_dev(cs_dev),
    .msg_status(msg_status), .msg_actual(msg_actual), .spurious(spurious)
  );

  spi_seq_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val), .expired(dly_expired)
  );

  spi_seq_csdrv #(.NUM_CS(NUM_CS), .DEV_W(DEV_W)) u_cs (
    .cs_act(cs_act), .dev(cs_dev), .cs_n(cs_n)
  );
endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int NUM_CS = 4,
  parameter int ACT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_valid,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [7:0]        rx_data,
  input logic              eng_load,
  input logic [NUM_CS-1:0] cs_n,
  input logic [1:0]        msg_status,
  input logic [ACT_W-1:0]  msg_actual
);
  p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  p_tx_to_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> eng_load);

  p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_err_cs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_status == 2'b11) |-> (&cs_n));

  p_ok_cs_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_status == 2'b10) |-> (&cs_n));

  p_no_load_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_status != 2'b01) |-> !eng_load);

  p_hold_actual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_status[1] && !desc_valid) |=> $stable(msg_actual));
endmodule

bind spi_seq_top spi_seq_chk #(.NUM_CS(NUM_CS), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid),
  .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .eng_load(eng_load), .cs_n(cs_n), .msg_status(msg_status), .msg_actual(msg_actual)
);

// File: tb/spi_seq_top_tb.sv
module spi_seq_top_tb;
  localparam int LEN_W = 8, DLY_W = 8, NUM_CS = 4, ACT_W = 12, DEV_W = 2, LAT = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic desc_valid, desc_ready, desc_has_tx, desc_store_rx, desc_cs_change, desc_last;
  logic [LEN_W-1:0] desc_len;
  logic [DLY_W-1:0] desc_delay;
  logic [DEV_W-1:0] desc_dev;
  logic [2:0] desc_mode, eng_mode;
  logic [7:0] desc_baud, eng_baud, tx_data, rx_data, eng_wdata, eng_rdata;
  logic tx_valid, tx_ready, rx_valid, rx_ready, eng_load, eng_done, eng_wcol, eng_modf, spurious;
  logic [NUM_CS-1:0] cs_n;
  logic [1:0] msg_status;
  logic [ACT_W-1:0] msg_actual;

  spi_seq_top #(.LEN_W(LEN_W), .DLY_W(DLY_W), .NUM_CS(NUM_CS), .ACT_W(ACT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_len(desc_len),
    .desc_has_tx(desc_has_tx), .desc_store_rx(desc_store_rx), .desc_delay(desc_delay),
    .desc_cs_change(desc_cs_change), .desc_last(desc_last), .desc_dev(desc_dev),
    .desc_mode(desc_mode), .desc_baud(desc_baud),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_mode(eng_mode), .eng_baud(eng_baud), .eng_load(eng_load), .eng_wdata(eng_wdata),
    .eng_done(eng_done), .eng_wcol(eng_wcol), .eng_modf(eng_modf), .eng_rdata(eng_rdata),
    .cs_n(cs_n), .msg_status(msg_status), .msg_actual(msg_actual), .spurious(spurious)
  );

  int errs = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] q_tx[$], q_load[$], q_rx[$];
  int wcol_at = -1, modf_at = -1, resp_idx = 0;
  bit tx_slow = 0, rx_slow = 0, inj_spur = 0, finished = 0;
  int cs_rise = 0, cs_bad = 0, spur_seen = 0, n_load = 0, txr_cnt = 0, done_cyc = 0, rel_cyc = 0;
  logic [DEV_W-1:0] exp_dev = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bus model and scoreboard monitor: transmit source, receive sink, engine
  initial begin
    int cnt_down;
    bit hs_tx, cs_low_prev;
    logic [7:0] wd, e;
    logic [NUM_CS-1:0] pat;
    cnt_down = 0; hs_tx = 0; cs_low_prev = 0; wd = '0;
    tx_valid = 0; tx_data = '0; rx_ready = 1;
    eng_done = 0; eng_wcol = 0; eng_modf = 0; eng_rdata = '0;
    forever begin
      @(negedge clk);
      if (hs_tx && q_tx.size() > 0) void'(q_tx.pop_front());
      tx_valid = (q_tx.size() > 0) && (!tx_slow || (cyc % 2 == 0));
      tx_data  = (q_tx.size() > 0) ? q_tx[0] : 8'h00;
      hs_tx    = tx_valid && tx_ready;
      if (tx_ready) txr_cnt++;
      rx_ready = !rx_slow || (cyc % 3 == 0);
      if (rx_valid && rx_ready) begin
        if (q_rx.size() == 0) chk(0, "R4 unexpected rx beat", rx_data, -1);
        else begin e = q_rx.pop_front(); chk(rx_data == e, "R4 rx byte", rx_data, e); end
      end
      if (spurious) spur_seen++;
      pat = '1; pat[exp_dev] = 1'b0;
      if (!(&cs_n) && cs_n != pat) cs_bad++;
      if (cs_low_prev && (&cs_n)) begin cs_rise++; rel_cyc = cyc; end
      cs_low_prev = !(&cs_n);
      eng_done = 0; eng_wcol = 0; eng_modf = 0;
      if (inj_spur) begin eng_done = 1; inj_spur = 0; end
      if (eng_load) begin
        n_load++;
        if (q_load.size() == 0) chk(0, "R3 unexpected load", eng_wdata, -1);
        else begin e = q_load.pop_front(); chk(eng_wdata == e, "R3 loaded byte", eng_wdata, e); end
        wd = eng_wdata; cnt_down = LAT;
      end else if (cnt_down > 0) begin
        cnt_down--;
        if (cnt_down == 0) begin
          if (resp_idx == modf_at) eng_modf = 1;
          else begin
            eng_done = 1; eng_rdata = wd ^ 8'h5A;
            if (resp_idx == wcol_at) begin eng_wcol = 1; q_load.push_front(wd); end
          end
          resp_idx++;
          done_cyc = cyc;
        end
      end
    end
  end

  // Driver: pushes expected bytes, then offers the descriptor
  task automatic give_desc(input int len, input bit has_tx, input bit store, input int dly,
                           input bit csch, input bit last, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = has_tx ? seed + 8'(i) : 8'h00;
      if (has_tx) q_tx.push_back(b);
      q_load.push_back(b);
      if (store) q_rx.push_back(b ^ 8'h5A);
    end
    @(negedge clk);
    desc_len = LEN_W'(len); desc_has_tx = has_tx; desc_store_rx = store;
    desc_delay = DLY_W'(dly); desc_cs_change = csch; desc_last = last;
    desc_valid = 1;
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic wait_end(input string req);
    int n;
    n = 0;
    while (!msg_status[1] && n < 5000) begin @(negedge clk); n++; end
    chk(msg_status[1] == 1'b1, req, n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int c0, r0, s0, l0;
    rst_n = 0; desc_valid = 0; desc_len = '0; desc_has_tx = 0; desc_store_rx = 0;
    desc_delay = '0; desc_cs_change = 0; desc_last = 0; desc_dev = '0; desc_mode = '0; desc_baud = '0;
    repeat (4) @(negedge clk);
    chk(&cs_n, "R1 cs_n in reset", cs_n, 15);
    rst_n = 1;
    @(negedge clk);
    chk(&cs_n, "R1 cs_n", cs_n, 15);
    chk(msg_status == 2'b00, "R1 status", msg_status, 0);
    chk(msg_actual == 0, "R1 actual", msg_actual, 0);
    chk(desc_ready && !eng_load && !rx_valid && !spurious, "R1 handshake idle", desc_ready, 1);

    // R2 R3 R10: four bytes from stream, device 2
    exp_dev = 2; desc_dev = 2; desc_mode = 3'b101; desc_baud = 8'h37;
    give_desc(4, 1, 0, 0, 0, 1, 8'h10);
    chk(eng_mode == 3'b101, "R2 mode", eng_mode, 5);
    chk(eng_baud == 8'h37, "R2 baud", eng_baud, 8'h37);
    chk(cs_n == 4'b1011, "R2 chip select", cs_n, 4'b1011);
    chk(msg_status == 2'b01, "R10 busy", msg_status, 1);
    wait_end("R10 end");
    chk(msg_status == 2'b10, "R10 ok", msg_status, 2);
    chk(msg_actual == 4, "R9 actual", msg_actual, 4);
    chk(q_load.size() == 0 && q_tx.size() == 0, "R3 all bytes loaded", q_load.size(), 0);

    // R3 R4: zero fill, received bytes stored under back-pressure
    exp_dev = 0; desc_dev = 0; rx_slow = 1; t0_txr();
    give_desc(3, 0, 1, 0, 0, 1, 8'h00);
    wait_end("R4 end");
    chk(txr_cnt == 0, "R3 tx_ready low without tx", txr_cnt, 0);
    chk(q_rx.size() == 0, "R4 all rx delivered", q_rx.size(), 0);
    chk(msg_actual == 3, "R9 actual", msg_actual, 3);
    rx_slow = 0;

    // R7: delay timing, 5 and 0
    give_desc(1, 1, 0, 5, 0, 1, 8'h80);
    wait_end("R7 end");
    chk(rel_cyc - done_cyc == 7, "R7 delay 5", rel_cyc - done_cyc, 7);
    give_desc(1, 1, 0, 0, 0, 1, 8'h90);
    wait_end("R7 end");
    chk(rel_cyc - done_cyc == 2, "R7 delay 0", rel_cyc - done_cyc, 2);

    // R8: chip select kept across boundary
    exp_dev = 3; desc_dev = 3; c0 = cs_rise; tx_slow = 1;
    give_desc(2, 1, 0, 1, 0, 0, 8'hA0);
    give_desc(3, 1, 1, 0, 0, 1, 8'hB0);
    wait_end("R8 end");
    chk(cs_rise - c0 == 1, "R8 cs kept low", cs_rise - c0, 1);
    chk(msg_actual == 5, "R9 two transfers", msg_actual, 5);
    tx_slow = 0;

    // R8: chip select dropped between transfers
    c0 = cs_rise;
    give_desc(2, 1, 0, 2, 1, 0, 8'hC0);
    give_desc(2, 0, 0, 0, 0, 1, 8'h00);
    wait_end("R8 end");
    chk(cs_rise - c0 == 2, "R8 cs released between", cs_rise - c0, 2);
    chk(cs_bad == 0, "R2 only selected device low", cs_bad, 0);

    // R5: collision on middle byte
    l0 = n_load; wcol_at = resp_idx + 1;
    give_desc(3, 1, 1, 0, 0, 1, 8'h20);
    wait_end("R5 end");
    chk(n_load - l0 == 4, "R5 reload count", n_load - l0, 4);
    chk(q_rx.size() == 0 && q_load.size() == 0, "R5 no extra rx", q_rx.size(), 0);
    chk(msg_actual == 3, "R5 length", msg_actual, 3);
    wcol_at = -1;

    // R6: fault on first byte of second transfer
    modf_at = resp_idx + 2;
    give_desc(2, 1, 0, 0, 0, 0, 8'h30);
    give_desc(3, 1, 0, 0, 0, 1, 8'h40);
    wait_end("R6 end");
    repeat (8) @(negedge clk);
    chk(msg_status == 2'b11, "R6 error status", msg_status, 3);
    chk(&cs_n, "R6 cs released", cs_n, 15);
    chk(msg_actual == 2, "R6 length kept", msg_actual, 2);
    chk(q_load.size() == 2, "R6 loads stopped", q_load.size(), 2);
    chk(desc_ready, "R6 back to idle", desc_ready, 1);
    q_load.delete(); q_tx.delete(); q_rx.delete(); modf_at = -1;

    // R11: spurious flag while idle
    s0 = spur_seen; l0 = n_load;
    @(posedge clk); inj_spur = 1;
    repeat (4) @(negedge clk);
    chk(spur_seen - s0 == 1, "R11 idle spurious", spur_seen - s0, 1);
    chk(msg_status == 2'b11 && msg_actual == 2, "R11 state kept", msg_actual, 2);
    chk(n_load == l0 && (&cs_n), "R11 no load", n_load - l0, 0);

    // R11 R9: spurious flag while waiting
    s0 = spur_seen; r0 = resp_idx;
    give_desc(1, 1, 0, 20, 0, 1, 8'h55);
    chk(msg_actual == 0, "R9 cleared at start", msg_actual, 0);
    while (resp_idx == r0) @(negedge clk);
    repeat (3) @(posedge clk); inj_spur = 1;
    wait_end("R11 end");
    chk(spur_seen - s0 == 1, "R11 wait spurious", spur_seen - s0, 1);
    chk(msg_status == 2'b10 && msg_actual == 1, "R11 wait unaffected", msg_actual, 1);
    chk(n_load - l0 == 1, "R11 no extra load", n_load - l0, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic t0_txr();
    @(negedge clk);
    txr_cnt = 0;
  endtask
endmodule